// File: doc/BRIEF.md
# Memory-Array Stage Sequencer

This block runs the memory-array stage of a pipelined memory controller. The map stage launches it with a one-cycle start request. On that request the block clears its step counter and captures the reference it is handed: a serial number and a set of attribute flags. It also records whether the reference is a refresh.

After launch, a step counter advances once per clock. A small computed lookup table, indexed by the step together with the refresh flag, decides two things: when the stage becomes free again, and when stores must be held off. The counter parks on its final step once the stage is free.

From the step number and the captured attributes, the block produces a data-wait and an I/O-wait. The map stage uses both to stall. The DRAM device itself lies outside this block.

Top module: `mem_stage_seq`

## Requirements
- R1: A synchronous reset leaves the stage free and idle, the step at 0, the serial number, refresh flag and all captured attributes at 0, and store-wait, data-wait and I/O-wait low.
- R2: A start request sets the step to 0 on the next edge. On that edge the block also captures the map-stage serial number and the write, I/O-fetch, dirty-I/O-fetch, uses-data and uses-low-data flags. Without a start, the captured values are kept.
- R3: The stage is active when it is not free or when a start is requested. While active without a start, the step increments by one. The free flag is reloaded from the table only on active cycles, and the table sets it on the step 6 to 7 transition. While the stage is not active, the step holds, so it parks at 7.
- R4: The idle output is high exactly when the stage is free and no start is requested.
- R5: On an active cycle, store-wait reloads to (captured write is 0) AND (the table's store-release bit for the current index is 0). The store-release bit is 0 only for step 1 with the refresh flag clear. On cycles that are not active, store-wait holds.
- R6: On a start, the refresh flag loads from the refresh request input. The table index is the step with the refresh flag placed just above it, so step and flag together select one of 32 entries.
- R7: Data-wait is high when the step is 7, the free flag was low on the previous cycle, and the captured uses-low-data flag is 0.
- R8: Data-wait is also high when the step is 6, the captured uses-data flag is 1, and the hold-disable input is low.
- R9: I/O-wait is high exactly when the step is 6 and the captured dirty-I/O-fetch flag is 1.
- R10: During a refresh run, store-wait never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_mem | input | 1 | Launch request from the map stage |
| map_srn | input | SRN_W | Serial number of the reference being launched |
| map_write | input | 1 | Reference is a write |
| map_io_fetch | input | 1 | Reference is an I/O fetch |
| map_dirty_io | input | 1 | Reference is a dirty I/O fetch |
| map_uses_data | input | 1 | Reference uses the data path |
| map_uses_low | input | 1 | Reference uses the low data bits |
| refresh_req | input | 1 | The launched cycle is a refresh |
| hold_disable | input | 1 | Suppresses the step-6 data-wait term |
| stage_free | output | 1 | Stage has finished its run |
| stage_idle | output | 1 | Free and no start requested |
| store_wait | output | 1 | Stores must be held off |
| data_wait | output | 1 | Data stall toward the map stage |
| io_wait | output | 1 | I/O stall toward the map stage |
| step | output | STATE_W | Current step number |
| mem_srn | output | SRN_W | Captured serial number |
| in_refresh | output | 1 | Captured refresh flag |

## Verification
The assertions assume the map stage raises start only while the stage is free. If a start arrived mid-run, the free flag could rise on a step other than 7.

The stimulus keeps to that assumption by gating every random start with the bench's own model of the free flag. Attributes, refresh choice and hold-disable are otherwise random each cycle. Directed runs cover a non-write run without refresh, where store-wait shows, and a refresh run, where it must not.

// File: rtl/mem_seq_pkg.sv
package mem_seq_pkg;

   // One table word: the two controls the sequencer consumes
   typedef struct packed {
      logic store_release;
      logic free_next;
   } rom_word_t;

   // Reference attributes captured at launch
   typedef struct packed {
      logic wr;
      logic io_fetch;
      logic dirty_io;
      logic uses_data;
      logic uses_low;
   } ref_attr_t;

endpackage

// File: rtl/mseq_rom.sv
module mseq_rom
   import mem_seq_pkg::*;
#(
   parameter int STATE_W    = 4,
   parameter int FINAL_STEP = 7,
   parameter int STORE_STEP = 1,
   parameter bit USE_TABLE  = 1'b1
) (
   input  logic [STATE_W:0] idx,
   output rom_word_t        word
);
   localparam int DEPTH = 2 ** (STATE_W + 1);
   localparam int STEPS = 2 ** STATE_W;

   function automatic rom_word_t entry(input int unsigned ix);
      rom_word_t   w;
      int unsigned st;
      logic        rf;
      st = ix % STEPS;
      rf = ((ix / STEPS) % 2) == 1;
      w.free_next     = (st == FINAL_STEP - 1) || (st > FINAL_STEP);
      w.store_release = rf || (st != STORE_STEP);
      return w;
   endfunction

   generate
      if (USE_TABLE) begin : g_table
         rom_word_t tab [DEPTH];
         for (genvar g = 0; g < DEPTH; g++) begin : g_ent
            assign tab[g] = entry(g);
         end
         assign word = tab[idx];
      end else begin : g_decode
         assign word = entry({{(31 - STATE_W){1'b0}}, idx});
      end
   endgenerate

endmodule

// File: rtl/mseq_attr.sv
module mseq_attr
   import mem_seq_pkg::*;
#(
   parameter int SRN_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [SRN_W-1:0] srn_in,
   input  ref_attr_t        attr_in,
   output logic [SRN_W-1:0] srn_q,
   output ref_attr_t        attr_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         srn_q  <= '0;
         attr_q <= '0;
      end else if (start) begin
         srn_q  <= srn_in;
         attr_q <= attr_in;
      end
   end

   // R2
   capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !start |=> (srn_q == $past(srn_q)) && (attr_q == $past(attr_q)));

endmodule

// File: rtl/mseq_ctl.sv
module mseq_ctl
   import mem_seq_pkg::*;
#(
   parameter int STATE_W    = 4,
   parameter int FINAL_STEP = 7,
   parameter int STORE_STEP = 1,
   parameter bit USE_TABLE  = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic               refresh_req,
   input  logic               wr_q,
   output logic [STATE_W-1:0] state,
   output logic               free,
   output logic               free_d,
   output logic               idle,
   output logic               store_wait,
   output logic               rfsh
);
   localparam logic [STATE_W-1:0] FINAL_S = STATE_W'(FINAL_STEP);
   localparam logic [STATE_W-1:0] ONE_S   = STATE_W'(1);

   rom_word_t         word;
   logic [STATE_W:0]  idx;
   logic              active;

   assign idx    = {rfsh, state};
   assign idle   = free & ~start;
   assign active = ~idle;

   mseq_rom #(
      .STATE_W   (STATE_W),
      .FINAL_STEP(FINAL_STEP),
      .STORE_STEP(STORE_STEP),
      .USE_TABLE (USE_TABLE)
   ) u_rom (
      .idx (idx),
      .word(word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state      <= '0;
         free       <= 1'b1;
         free_d     <= 1'b1;
         store_wait <= 1'b0;
         rfsh       <= 1'b0;
      end else begin
         free_d <= free;
         if (start) begin
            state <= '0;
            rfsh  <= refresh_req;
         end else if (active) begin
            state <= state + ONE_S;
         end
         if (active) begin
            free       <= word.free_next;
            store_wait <= ~wr_q & ~word.store_release;
         end
      end
   end

   // R2
   start_clears_chk: assert property (@(posedge clk) disable iff (rst)
      start |=> state == '0);

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      idle |=> state == $past(state));

   // R3
   free_at_final_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(free) |-> state == FINAL_S);

   // R5
   store_hold_chk: assert property (@(posedge clk) disable iff (rst)
      idle |=> $stable(store_wait));

endmodule

// File: rtl/mem_stage_seq.sv
module mem_stage_seq
   import mem_seq_pkg::*;
#(
   parameter int SRN_W      = 4,
   parameter int STATE_W    = 4,
   parameter int FINAL_STEP = 7,
   parameter int STORE_STEP = 1,
   parameter bit USE_TABLE  = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start_mem,
   input  logic [SRN_W-1:0]   map_srn,
   input  logic               map_write,
   input  logic               map_io_fetch,
   input  logic               map_dirty_io,
   input  logic               map_uses_data,
   input  logic               map_uses_low,
   input  logic               refresh_req,
   input  logic               hold_disable,
   output logic               stage_free,
   output logic               stage_idle,
   output logic               store_wait,
   output logic               data_wait,
   output logic               io_wait,
   output logic [STATE_W-1:0] step,
   output logic [SRN_W-1:0]   mem_srn,
   output logic               in_refresh
);
   localparam logic [STATE_W-1:0] FINAL_S = STATE_W'(FINAL_STEP);
   localparam logic [STATE_W-1:0] PREV_S  = STATE_W'(FINAL_STEP - 1);

   generate
      if (FINAL_STEP < 2 || FINAL_STEP >= 2 ** STATE_W) begin : g_bad_final
         $error("FINAL_STEP must lie in 2 .. 2**STATE_W-1");
      end
      if (STORE_STEP < 0 || STORE_STEP >= FINAL_STEP) begin : g_bad_store
         $error("STORE_STEP must lie below FINAL_STEP");
      end
      if (SRN_W < 1) begin : g_bad_srn
         $error("SRN_W must be positive");
      end
   endgenerate

   ref_attr_t attr_in, attr_q;
   logic      free_d;

   assign attr_in = '{wr:        map_write,
                      io_fetch:  map_io_fetch,
                      dirty_io:  map_dirty_io,
                      uses_data: map_uses_data,
                      uses_low:  map_uses_low};

   mseq_attr #(.SRN_W(SRN_W)) u_attr (
      .clk    (clk),
      .rst    (rst),
      .start  (start_mem),
      .srn_in (map_srn),
      .attr_in(attr_in),
      .srn_q  (mem_srn),
      .attr_q (attr_q)
   );

   mseq_ctl #(
      .STATE_W   (STATE_W),
      .FINAL_STEP(FINAL_STEP),
      .STORE_STEP(STORE_STEP),
      .USE_TABLE (USE_TABLE)
   ) u_ctl (
      .clk        (clk),
      .rst        (rst),
      .start      (start_mem),
      .refresh_req(refresh_req),
      .wr_q       (attr_q.wr),
      .state      (step),
      .free       (stage_free),
      .free_d     (free_d),
      .idle       (stage_idle),
      .store_wait (store_wait),
      .rfsh       (in_refresh)
   );

   logic dw_last, dw_prev;
   assign dw_last   = (step == FINAL_S) & ~free_d & ~attr_q.uses_low;
   assign dw_prev   = (step == PREV_S) & attr_q.uses_data & ~hold_disable;
   assign data_wait = dw_last | dw_prev;
   assign io_wait   = (step == PREV_S) & attr_q.dirty_io;

   // R9
   io_wait_step_chk: assert property (@(posedge clk) disable iff (rst)
      io_wait |-> (step == PREV_S) && !stage_free);

   // R7
   data_wait_step_chk: assert property (@(posedge clk) disable iff (rst)
      data_wait |-> (step == PREV_S) || (step == FINAL_S));

   // R7
   data_wait_once_chk: assert property (@(posedge clk) disable iff (rst)
      (step == FINAL_S && stage_idle) |=> !dw_last);

endmodule

// File: tb/tb_mem_stage_seq.sv
module tb_mem_stage_seq;
   localparam int CLK_PERIOD = 10;
   localparam int SRN_W = 4;
   localparam int STATE_W = 4;
   localparam int FIN = 7;
   localparam int STORE = 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start_mem = 1'b0;
   logic [SRN_W-1:0] map_srn = '0;
   logic map_write = 1'b0, map_io_fetch = 1'b0, map_dirty_io = 1'b0;
   logic map_uses_data = 1'b0, map_uses_low = 1'b0;
   logic refresh_req = 1'b0, hold_disable = 1'b0;
   logic stage_free, stage_idle, store_wait, data_wait, io_wait, in_refresh;
   logic [STATE_W-1:0] step;
   logic [SRN_W-1:0] mem_srn;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mem_stage_seq dut (
      .clk(clk), .rst(rst), .start_mem(start_mem), .map_srn(map_srn),
      .map_write(map_write), .map_io_fetch(map_io_fetch),
      .map_dirty_io(map_dirty_io), .map_uses_data(map_uses_data),
      .map_uses_low(map_uses_low), .refresh_req(refresh_req),
      .hold_disable(hold_disable), .stage_free(stage_free),
      .stage_idle(stage_idle), .store_wait(store_wait),
      .data_wait(data_wait), .io_wait(io_wait), .step(step),
      .mem_srn(mem_srn), .in_refresh(in_refresh)
   );

   // Reference model built from the requirements
   int m_state = 0;
   bit m_free = 1, m_free_d = 1, m_sw = 0, m_rf = 0;
   bit m_wr = 0, m_dirty = 0, m_uses = 0, m_low = 0;
   int m_srn = 0;

   function automatic bit e_free_next(int st);
      return (st == FIN - 1) || (st > FIN);
   endfunction

   function automatic bit e_store_release(bit rf, int st);
      return rf || (st != STORE);
   endfunction

   always @(posedge clk) begin
      bit act;
      if (rst) begin
         m_state = 0; m_free = 1; m_free_d = 1; m_sw = 0; m_rf = 0;
         m_wr = 0; m_dirty = 0; m_uses = 0; m_low = 0; m_srn = 0;
      end else begin
         act = !(m_free && !start_mem);
         m_free_d = m_free;
         if (act) begin
            m_sw   = !m_wr && !e_store_release(m_rf, m_state);
            m_free = e_free_next(m_state);
         end
         if (start_mem) begin
            m_state = 0;
            m_rf = refresh_req;
            m_wr = map_write; m_dirty = map_dirty_io;
            m_uses = map_uses_data; m_low = map_uses_low;
            m_srn = int'(map_srn);
         end else if (act) begin
            m_state = (m_state + 1) % (2 ** STATE_W);
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Compare every output with the model, away from the clock edge
   task automatic compare_all();
      bit e_dw, e_io;
      e_dw = (m_state == FIN && !m_free_d && !m_low) ||
             (m_state == FIN - 1 && m_uses && !hold_disable);
      e_io = (m_state == FIN - 1) && m_dirty;
      chk("R3", "step", int'(step), m_state);
      chk("R3", "free", int'(stage_free), int'(m_free));
      chk("R4", "idle", int'(stage_idle), int'(m_free && !start_mem));
      chk("R5", "store_wait", int'(store_wait), int'(m_sw));
      chk((m_state == FIN) ? "R7" : "R8", "data_wait", int'(data_wait), int'(e_dw));
      chk("R9", "io_wait", int'(io_wait), int'(e_io));
      chk("R2", "srn", int'(mem_srn), m_srn);
      chk("R6", "refresh", int'(in_refresh), int'(m_rf));
   endtask

   task automatic cycle();
      @(negedge clk);
      compare_all();
   endtask

   task automatic launch(input bit wr, input bit dirty, input bit uses,
                         input bit low, input bit rf, input int srn);
      start_mem = 1'b1; map_write = wr; map_dirty_io = dirty;
      map_uses_data = uses; map_uses_low = low; refresh_req = rf;
      map_srn = SRN_W'(srn); map_io_fetch = dirty;
      cycle();
      start_mem = 1'b0;
   endtask

   initial begin
      int sw_seen;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "free", int'(stage_free), 1);
      chk("R1", "idle", int'(stage_idle), 1);
      chk("R1", "step", int'(step), 0);
      chk("R1", "waits", int'({store_wait, data_wait, io_wait}), 0);
      chk("R1", "srn", int'(mem_srn), 0);
      rst = 1'b0;
      cycle();

      // Directed: plain read run, store-wait visible at step 2 (R5)
      launch(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 9);
      chk("R2", "step after start", int'(step), 0);
      chk("R2", "srn captured", int'(mem_srn), 9);
      cycle();
      cycle();
      chk("R5", "store_wait at step 2", int'(store_wait), 1);
      repeat (4) cycle();
      chk("R8", "data_wait at step 6", int'(data_wait), 1);
      chk("R9", "io_wait at step 6", int'(io_wait), 1);
      cycle();
      chk("R7", "data_wait at step 7", int'(data_wait), 1);
      chk("R3", "free at step 7", int'(stage_free), 1);
      cycle();
      chk("R7", "data_wait drops", int'(data_wait), 0);
      chk("R3", "parked at 7", int'(step), FIN);

      // Directed: refresh run, no store-wait (R10), hold-disable masks R8
      hold_disable = 1'b1;
      launch(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 3);
      sw_seen = 0;
      for (int i = 0; i < 10; i++) begin
         cycle();
         if (store_wait) sw_seen++;
         if (step == STATE_W'(FIN - 1))
            chk("R8", "masked by hold_disable", int'(data_wait), 0);
      end
      chk("R10", "store_wait during refresh", sw_seen, 0);
      chk("R6", "refresh flag", int'(in_refresh), 1);
      hold_disable = 1'b0;

      // Random traffic, starts only while model says free
      void'($urandom(32'd4242));
      for (int i = 0; i < 4000; i++) begin
         start_mem     = m_free && ($urandom % 4 == 0);
         map_write     = $urandom % 2;
         map_io_fetch  = $urandom % 2;
         map_dirty_io  = $urandom % 2;
         map_uses_data = $urandom % 2;
         map_uses_low  = $urandom % 2;
         refresh_req   = ($urandom % 3 == 0);
         hold_disable  = ($urandom % 4 == 0);
         map_srn       = SRN_W'($urandom);
         cycle();
      end
      start_mem = 1'b0;

      // Reset mid-stream returns to R1 state
      launch(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5);
      rst = 1'b1;
      cycle();
      chk("R1", "free after reset", int'(stage_free), 1);
      chk("R1", "step after reset", int'(step), 0);
      rst = 1'b0;

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule